// File: doc/BRIEF.md
# Reversible Permutation Property Classifier

This block takes the complete truth table of a mapping on `N` wires, one output word for each of the `2^N` input words. It decides which restricted families of reversible gate networks could realise that mapping. Software or a sequencer writes the table entry by entry while the block is idle, then pulses `start`. The block first scans the table for repeated output words. A table with a repeat is not a bijection, and the block reports only that fact.

For a true permutation, a walker follows every cycle of the mapping and counts the cycles, which gives the parity. A GF(2) elimination engine then tests whether the images of the single-one words `2^i` are linearly independent. From these results and two direct table probes, the block reports a set of flags:

- whether the mapping fixes the zero word;
- whether it fixes every single-one word;
- whether a scratch wire is needed;
- whether the necessary conditions hold for a Toffoli-only network;
- whether the necessary conditions hold for Toffoli gates followed by CNOT gates.

The flags become valid in the cycle of a one-cycle `done` pulse. They hold until the next `start`.

Top module: `perm_prop_classifier`

## Requirements
- R1: While `busy` is low, a cycle with `wr_en` high stores `wr_data` as the image of input word `wr_addr`. After reset, the table holds the identity mapping.
- R2: While `busy` is high, `wr_en` and `start` have no effect. The table, the run length and the results are unchanged.
- R3: If any output word appears twice in the table, `perm_bad` is 1 and every other result flag is 0. In that case `busy` stays high for exactly `2^N` cycles.
- R4: `perm_even` is 1 exactly when the permutation is a product of an even number of transpositions. `needs_scratch` is its complement for a valid permutation.
- R5: `fix_zero` is 1 exactly when input word 0 maps to 0.
- R6: `fix_units` is 1 exactly when every word with a single bit set (1, 2, 4, ...) maps to itself.
- R7: `units_indep` is 1 exactly when the `N` images of the single-one words are linearly independent over GF(2), meaning no non-empty subset of them XORs to zero.
- R8: `toff_cond` is 1 exactly when `fix_zero` and `fix_units` are both 1 and, for `N` of 4 or more, the permutation is also even.
- R9: `toff_cnot_cond` is 1 exactly when `fix_zero` and `units_indep` are both 1. For `N`=3, the mapping that swaps 1 with 2 and 3 with 4 gives 0.
- R10: For a valid permutation, `busy` stays high for exactly `3*2^N+N` cycles after the `start` edge. `done` is then high for one cycle with `busy` low. The flags read 0 while `busy` is high and hold their values after `done`.
- R11: After reset, `busy`, `done` and every result flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | N | Input word whose image is written |
| wr_data | input | N | Image of `wr_addr` |
| start | input | 1 | Begin classification of the stored table |
| busy | output | 1 | Classification in progress |
| done | output | 1 | One-cycle pulse: results valid |
| perm_bad | output | 1 | Table contains a repeated output word |
| perm_even | output | 1 | Permutation is even |
| needs_scratch | output | 1 | Permutation is odd, so one scratch wire is required |
| fix_zero | output | 1 | Word 0 maps to 0 |
| fix_units | output | 1 | Every single-one word maps to itself |
| units_indep | output | 1 | Images of single-one words are GF(2) independent |
| toff_cond | output | 1 | Necessary conditions for a Toffoli-only network hold |
| toff_cnot_cond | output | 1 | Necessary conditions for a Toffoli-then-CNOT network hold |

## Verification
The hardest situation to reach from the ports is an attempt to disturb the table in the middle of a run. A write and a repeated `start` during `busy` must leave both the run length and a later re-run unchanged. The bench therefore injects, mid-run, a write that would make the table non-bijective, together with a second start pulse. It checks the busy length of that run cycle by cycle, then re-runs the same table without reloading it and expects identical flags. Dependent unit images and odd permutations that still fix every unit word are built by hand. Randomly shuffled tables, some with a forced repeat, cover the rest.

// File: rtl/perm_cls_pkg.sv
// Shared types for the permutation property classifier.
package perm_cls_pkg;
    // Top-level sequencing phases.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SCAN = 2'd1,
        PH_CYC  = 2'd2,
        PH_ELIM = 2'd3
    } phase_t;
endpackage

// File: rtl/perm_table.sv
// perm_table: register store for the 2^N images of the mapping.
// Assumes: writes are only accepted while unlocked; reset loads identity.
module perm_table #(
    parameter int N = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [N-1:0]          wr_addr,
    input  logic [N-1:0]          wr_data,
    input  logic                  locked,
    output logic [(2**N)*N-1:0]   table_flat
);
    localparam int E = 2**N;

    logic [N-1:0] mem [E];

    // Store one image per write; identity after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < E; i++) mem[i] <= N'(i);
        end else if (wr_en && !locked) begin
            mem[wr_addr] <= wr_data;
        end
    end

    generate
        for (genvar g = 0; g < E; g++) begin : g_flat
            assign table_flat[g*N +: N] = mem[g];
        end
    endgenerate

    // R2
    hold_when_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(table_flat));
endmodule

// File: rtl/dup_checker.sv
// dup_checker: marks each probed image in a seen bitmap and flags repeats.
// Assumes: one probe per step cycle, clear before each scan.
module dup_checker #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         step,
    input  logic [N-1:0] probe,
    output logic         dup_now
);
    localparam int E = 2**N;

    logic [E-1:0] seen;
    logic         dup_q;

    // Repeat seen so far, including the current probe.
    assign dup_now = dup_q | seen[probe];

    // Bitmap and sticky repeat flag update.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            seen  <= '0;
            dup_q <= 1'b0;
        end else if (step) begin
            seen[probe] <= 1'b1;
            dup_q       <= dup_now;
        end
    end

    // R3
    seen_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear) |=> seen[$past(probe)]);
endmodule

// File: rtl/cycle_walker.sv
// cycle_walker: counts the cycles of a bijective table by following each
// unvisited entry until it returns to its start point. Takes exactly 2*2^N
// cycles after go: one visit per index plus one follow step per entry.
// Assumes: the table is a bijection and is stable while active.
module cycle_walker #(
    parameter int N = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 go,
    input  logic [(2**N)*N-1:0]  table_flat,
    output logic                 last_step,
    output logic                 cycles_odd
);
    localparam int E  = 2**N;
    localparam int CW = $clog2(E+1);
    localparam logic [N-1:0] LAST = N'(E-1);

    logic          active, following;
    logic [N-1:0]  idx, cur, anchor, nxt;
    logic [E-1:0]  visited;
    logic [CW-1:0] count;

    assign nxt        = table_flat[int'(cur)*N +: N];
    assign cycles_odd = count[0];

    // Final cycle of the walk, seen one cycle early by the sequencer.
    always_comb begin
        last_step = 1'b0;
        if (active && idx == LAST) begin
            if (!following) last_step = visited[idx];
            else            last_step = (nxt == anchor);
        end
    end

    // Index scan and cycle following.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            following <= 1'b0;
            idx       <= '0;
            cur       <= '0;
            anchor    <= '0;
            visited   <= '0;
            count     <= '0;
        end else if (go) begin
            active    <= 1'b1;
            following <= 1'b0;
            idx       <= '0;
            visited   <= '0;
            count     <= '0;
        end else if (active) begin
            if (!following) begin
                if (visited[idx]) begin
                    if (idx == LAST) active <= 1'b0;
                    else             idx    <= idx + 1'b1;
                end else begin
                    count     <= count + 1'b1;
                    cur       <= idx;
                    anchor    <= idx;
                    following <= 1'b1;
                end
            end else begin
                visited[cur] <= 1'b1;
                if (nxt == anchor) begin
                    following <= 1'b0;
                    if (idx == LAST) active <= 1'b0;
                    else             idx    <= idx + 1'b1;
                end else begin
                    cur <= nxt;
                end
            end
        end
    end

    // R4
    all_visited_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_step |=> (&visited));
    // R4
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (int'(count) <= E));
endmodule

// File: rtl/gf2_rank.sv
// gf2_rank: Gaussian elimination over GF(2) on N row vectors, one pivot
// column per cycle, N cycles after load.
// Assumes: vectors are stable at the load cycle only.
module gf2_rank #(
    parameter int N = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [N*N-1:0]   vecs_flat,
    output logic             last_step,
    output logic             indep_now
);
    localparam int RW = $clog2(N+1);
    localparam int PW = $clog2(N);

    logic [N-1:0]  rows [N];
    logic [N-1:0]  used;
    logic [RW-1:0] rank;
    logic [PW-1:0] col, piv;
    logic          active, found;

    // Lowest unused row holding a one in the current column.
    always_comb begin
        found = 1'b0;
        piv   = '0;
        for (int r = N-1; r >= 0; r--) begin
            if (rows[r][col] && !used[r]) begin
                found = 1'b1;
                piv   = PW'(r);
            end
        end
    end

    assign last_step = active && (col == PW'(N-1));
    assign indep_now = (rank + RW'(found)) == RW'(N);

    // One elimination step per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            used   <= '0;
            rank   <= '0;
            col    <= '0;
            for (int r = 0; r < N; r++) rows[r] <= '0;
        end else if (load) begin
            active <= 1'b1;
            used   <= '0;
            rank   <= '0;
            col    <= '0;
            for (int r = 0; r < N; r++) rows[r] <= vecs_flat[r*N +: N];
        end else if (active) begin
            if (found) begin
                used[piv] <= 1'b1;
                rank      <= rank + 1'b1;
                for (int r = 0; r < N; r++) begin
                    if (PW'(r) != piv && rows[r][col]) rows[r] <= rows[r] ^ rows[piv];
                end
            end
            if (last_step) active <= 1'b0;
            else           col    <= col + 1'b1;
        end
    end

    // R7
    rank_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(used) == int'(rank));
    // R7
    rank_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rank) <= N);
endmodule

// File: rtl/perm_prop_classifier.sv
// perm_prop_classifier: sequences a repeat scan, a cycle walk and a GF(2)
// elimination over the stored table, then latches the property flags.
// Assumes: N in 3..6; the table is only written while idle.
module perm_prop_classifier #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [N-1:0] wr_addr,
    input  logic [N-1:0] wr_data,
    input  logic         start,
    output logic         busy,
    output logic         done,
    output logic         perm_bad,
    output logic         perm_even,
    output logic         needs_scratch,
    output logic         fix_zero,
    output logic         fix_units,
    output logic         units_indep,
    output logic         toff_cond,
    output logic         toff_cnot_cond
);
    import perm_cls_pkg::*;

    localparam int E = 2**N;
    localparam logic [N-1:0] LAST = N'(E-1);
    localparam logic SMALL_N = (N < 4);

    phase_t               phase;
    logic [N-1:0]         scan_idx;
    logic [E*N-1:0]       table_flat;
    logic [N*N-1:0]       unit_imgs;
    logic [N-1:0]         unit_fixed;
    logic                 dup_now, scan_last, walk_go, walk_last, elim_last, indep_now;
    logic                 cyc_odd, zero_ok, units_ok;

    assign busy = (phase != PH_IDLE);

    perm_table #(.N(N)) i_table (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .locked(busy), .table_flat(table_flat)
    );

    dup_checker #(.N(N)) i_dup (
        .clk(clk), .rst_n(rst_n),
        .clear(phase == PH_IDLE && start),
        .step(phase == PH_SCAN),
        .probe(table_flat[int'(scan_idx)*N +: N]),
        .dup_now(dup_now)
    );

    assign scan_last = (phase == PH_SCAN) && (scan_idx == LAST);
    assign walk_go   = scan_last && !dup_now;

    cycle_walker #(.N(N)) i_walk (
        .clk(clk), .rst_n(rst_n), .go(walk_go), .table_flat(table_flat),
        .last_step(walk_last), .cycles_odd(cyc_odd)
    );

    // Images of the single-one words and their fixed-point test.
    generate
        for (genvar b = 0; b < N; b++) begin : g_unit
            assign unit_imgs[b*N +: N] = table_flat[(2**b)*N +: N];
            assign unit_fixed[b]       = (table_flat[(2**b)*N +: N] == N'(2**b));
        end
    endgenerate

    assign zero_ok  = (table_flat[N-1:0] == '0);
    assign units_ok = &unit_fixed;

    gf2_rank #(.N(N)) i_rank (
        .clk(clk), .rst_n(rst_n),
        .load((phase == PH_CYC) && walk_last),
        .vecs_flat(unit_imgs),
        .last_step(elim_last), .indep_now(indep_now)
    );

    // Phase sequencing and result latching.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase          <= PH_IDLE;
            scan_idx       <= '0;
            done           <= 1'b0;
            perm_bad       <= 1'b0;
            perm_even      <= 1'b0;
            needs_scratch  <= 1'b0;
            fix_zero       <= 1'b0;
            fix_units      <= 1'b0;
            units_indep    <= 1'b0;
            toff_cond      <= 1'b0;
            toff_cnot_cond <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase          <= PH_SCAN;
                        scan_idx       <= '0;
                        perm_bad       <= 1'b0;
                        perm_even      <= 1'b0;
                        needs_scratch  <= 1'b0;
                        fix_zero       <= 1'b0;
                        fix_units      <= 1'b0;
                        units_indep    <= 1'b0;
                        toff_cond      <= 1'b0;
                        toff_cnot_cond <= 1'b0;
                    end
                end
                PH_SCAN: begin
                    scan_idx <= scan_idx + 1'b1;
                    if (scan_last) begin
                        if (dup_now) begin
                            phase    <= PH_IDLE;
                            done     <= 1'b1;
                            perm_bad <= 1'b1;
                        end else begin
                            phase <= PH_CYC;
                        end
                    end
                end
                PH_CYC: begin
                    if (walk_last) phase <= PH_ELIM;
                end
                PH_ELIM: begin
                    if (elim_last) begin
                        phase          <= PH_IDLE;
                        done           <= 1'b1;
                        perm_even      <= !cyc_odd;
                        needs_scratch  <= cyc_odd;
                        fix_zero       <= zero_ok;
                        fix_units      <= units_ok;
                        units_indep    <= indep_now;
                        toff_cond      <= zero_ok && units_ok && (!cyc_odd || SMALL_N);
                        toff_cnot_cond <= zero_ok && indep_now;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R3
    bad_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        perm_bad |-> !(perm_even || needs_scratch || fix_zero || fix_units ||
                       units_indep || toff_cond || toff_cnot_cond));
    // R4
    scratch_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !perm_bad) |-> (needs_scratch != perm_even));
endmodule

// File: tb/test_perm_prop_classifier.sv
module test_perm_prop_classifier;
    localparam int N = 3;
    localparam int E = 2**N;
    localparam int L_GOOD = 3*E + N;
    localparam int L_BAD  = E;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [N-1:0] wr_addr = '0;
    logic [N-1:0] wr_data = '0;
    logic start = 1'b0;
    logic busy, done, perm_bad, perm_even, needs_scratch, fix_zero, fix_units;
    logic units_indep, toff_cond, toff_cnot_cond;

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    bit finished = 1'b0;
    int tab [E];
    int e_bad, e_even, e_fz, e_fu, e_ind, e_t, e_tc;

    always #5 clk = ~clk;

    perm_prop_classifier #(.N(N)) i_perm_prop_classifier (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .start(start), .busy(busy), .done(done), .perm_bad(perm_bad),
        .perm_even(perm_even), .needs_scratch(needs_scratch), .fix_zero(fix_zero),
        .fix_units(fix_units), .units_indep(units_indep), .toff_cond(toff_cond),
        .toff_cnot_cond(toff_cnot_cond)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Behavioural reference: repeats, inversion parity, subset-XOR independence.
    task automatic model();
        int inv, x;
        bit dep;
        e_bad = 0;
        for (int i = 0; i < E; i++)
            for (int j = i+1; j < E; j++)
                if (tab[i] == tab[j]) e_bad = 1;
        inv = 0;
        for (int i = 0; i < E; i++)
            for (int j = i+1; j < E; j++)
                if (tab[i] > tab[j]) inv++;
        dep = 1'b0;
        for (int m = 1; m < E; m++) begin
            x = 0;
            for (int b = 0; b < N; b++) if (m[b]) x = x ^ tab[1<<b];
            if (x == 0) dep = 1'b1;
        end
        e_even = (inv % 2 == 0) ? 1 : 0;
        e_fz = (tab[0] == 0) ? 1 : 0;
        e_fu = 1;
        for (int b = 0; b < N; b++) if (tab[1<<b] != (1<<b)) e_fu = 0;
        e_ind = dep ? 0 : 1;
        e_t  = (e_fz && e_fu && (e_even || N < 4)) ? 1 : 0;
        e_tc = (e_fz && e_ind) ? 1 : 0;
        if (e_bad) begin
            e_even = 0; e_fz = 0; e_fu = 0; e_ind = 0; e_t = 0; e_tc = 0;
        end
    endtask

    task automatic load_table();
        for (int i = 0; i < E; i++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = N'(i); wr_data = tab[i][N-1:0];
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check_flags(input string tag);
        chk(perm_bad == e_bad[0],       {"R3 perm_bad ", tag}, perm_bad, e_bad);
        chk(perm_even == e_even[0],     {"R4 perm_even ", tag}, perm_even, e_even);
        chk(needs_scratch == (e_bad == 0 && e_even == 0), {"R4 needs_scratch ", tag},
            needs_scratch, (e_bad == 0 && e_even == 0));
        chk(fix_zero == e_fz[0],        {"R5 fix_zero ", tag}, fix_zero, e_fz);
        chk(fix_units == e_fu[0],       {"R6 fix_units ", tag}, fix_units, e_fu);
        chk(units_indep == e_ind[0],    {"R7 units_indep ", tag}, units_indep, e_ind);
        chk(toff_cond == e_t[0],        {"R8 toff_cond ", tag}, toff_cond, e_t);
        chk(toff_cnot_cond == e_tc[0],  {"R9 toff_cnot_cond ", tag}, toff_cnot_cond, e_tc);
    endtask

    // Start a run and compare busy/done/flags on every clock against the model.
    task automatic run_case(input string tag, input bit disturb);
        int len;
        model();
        len = e_bad ? L_BAD : L_GOOD;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int k = 0; k < len; k++) begin
            chk(busy == 1'b1 && done == 1'b0, {"R10 busy window ", tag}, {busy, done}, 2);
            chk({perm_bad, perm_even, fix_zero, units_indep} == 4'b0,
                {"R10 flags clear while busy ", tag}, {perm_bad, perm_even, fix_zero, units_indep}, 0);
            if (disturb && k == 2) begin
                // R2: a write creating a repeat, plus a second start, mid-run.
                wr_en = 1'b1; wr_addr = '0; wr_data = tab[0][N-1:0] ^ 1'b1; start = 1'b1;
            end
            @(negedge clk);
            wr_en = 1'b0; start = 1'b0;
        end
        chk(busy == 1'b0 && done == 1'b1, {"R10 done pulse ", tag}, {busy, done}, 1);
        check_flags(tag);
        @(negedge clk);
        chk(done == 1'b0, {"R10 done one cycle ", tag}, done, 0);
        check_flags({tag, " held"});
    endtask

    // Watchdog: a hung run is a failed check and still ends with the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            miscompares++;
            $display("FAIL R10 watchdog: actual %0d expected %0d", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        int a, b, t;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk({busy, done, perm_bad, perm_even, needs_scratch, fix_zero, fix_units,
             units_indep, toff_cond, toff_cnot_cond} == '0, "R11 reset outputs", busy, 0);

        // R1: identity left by reset, no writes.
        for (int i = 0; i < E; i++) tab[i] = i;
        run_case("reset identity R1", 1'b0);

        // R9: swap 1<->2 and 3<->4 on three wires.
        for (int i = 0; i < E; i++) tab[i] = i;
        tab[1] = 2; tab[2] = 1; tab[3] = 4; tab[4] = 3;
        load_table();
        run_case("double swap R9", 1'b0);

        // R8: odd permutation fixing 0 and units (swap 3<->5).
        for (int i = 0; i < E; i++) tab[i] = i;
        tab[3] = 5; tab[5] = 3;
        load_table();
        run_case("odd unit-fixing R8", 1'b0);

        // R5: bitwise complement moves 0.
        for (int i = 0; i < E; i++) tab[i] = i ^ (E-1);
        load_table();
        run_case("complement R5", 1'b0);

        // R7: bit rotation is linear and invertible.
        for (int i = 0; i < E; i++) tab[i] = ((i << 1) | (i >> (N-1))) & (E-1);
        load_table();
        run_case("rotation R7", 1'b0);

        // R3: repeat in the middle and at the last entry.
        for (int i = 0; i < E; i++) tab[i] = i;
        tab[6] = 5;
        load_table();
        run_case("repeat mid R3", 1'b0);
        for (int i = 0; i < E; i++) tab[i] = i;
        tab[E-1] = 0;
        load_table();
        run_case("repeat last R3", 1'b0);

        // R2: disturbed run, then re-run without reload.
        for (int i = 0; i < E; i++) tab[i] = (i * 3 + 1) % E;
        load_table();
        run_case("disturbed R2", 1'b1);
        run_case("rerun R2", 1'b0);

        // R4: shuffled tables, some with a forced repeat.
        for (int r = 0; r < 24; r++) begin
            for (int i = 0; i < E; i++) tab[i] = i;
            for (int i = E-1; i > 0; i--) begin
                a = $urandom_range(i, 0);
                t = tab[i]; tab[i] = tab[a]; tab[a] = t;
            end
            if (r % 5 == 4) begin
                a = $urandom_range(E-1, 0);
                b = (a + 1 + $urandom_range(E-2, 0)) % E;
                tab[b] = tab[a];
            end
            load_table();
            run_case("shuffle R4", 1'b0);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule